// File: doc/BRIEF.md
# Multi-Lane Programmable Input Deglitcher

This block cleans up slow, noisy input pins before other logic uses them. Each lane carries one raw pin through a two-stage synchronizer. It then holds back any new level until that level has stayed put for a programmable window. A lane's window is the product of a 4-bit count and a power of two picked by a 4-bit select, so a short window and a very long one use the same small fields. The window, counted in clock cycles, is `count << select`. A count of zero turns the lane into a plain synchronizer.

Inside each lane, a prescaler divides the clock by `2^select`. A stability counter advances on each prescaler tick while the synchronized level differs from the clean output. The clean output flips when that counter reaches the count. If the input returns to the clean level before then, both counters go back to zero. A lane takes its count and select at the first cycle of a qualification and keeps them until that qualification ends. Rewriting the configuration therefore never cuts short or stretches a window already in progress.

Top module: `dgl_filter_bank`

## Requirements
- R1: A pin level sampled at rising edge k reaches the synchronized level at edge k+1. With count 0 it reaches `pin_clean` at edge k+2.
- R2: With count 0 the lane does not filter. Every level passes, including a pulse one clock wide, at the R1 latency.
- R3: With count nonzero, `pin_clean` takes the synchronized level on the N-th consecutive rising edge at which the two differ. N = count × 2^select, where count is 0..15 and select is 0..15.
- R4: If the synchronized level returns to `pin_clean` before N is reached, the lane keeps its output and discards all progress. A later difference again needs a full N edges.
- R5: Reset is synchronous and active high. While it is asserted, `pin_clean` follows the synchronized level every cycle, so after release no transition appears until the pin really changes.
- R6: A lane latches count and select on the first edge of a qualification. A configuration change while that qualification runs does not alter its window and applies from the next qualification.
- R7: Lanes are independent. Lane i takes its count from `win_count[i*4 +: 4]` and its select from `win_select[i*4 +: 4]`.
- R8: `pin_clean` only ever changes to the current synchronized level. It never changes on an edge where the synchronized level already equals it.
- R9: Select 4 with count 9 gives a window of exactly 144 clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Filter clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_raw | input | NUM_PINS | Asynchronous raw pin levels |
| win_count | input | NUM_PINS*CNT_W | Per-lane window count, 0 means bypass |
| win_select | input | NUM_PINS*SEL_W | Per-lane prescale exponent |
| pin_clean | output | NUM_PINS | Registered filtered levels |

## Verification
Two events can land on the same clock edge. In the first, a configuration rewrite arrives on the edge where a difference first appears, and the lane must use the value present before that edge. In the second, the input returns to the clean level on the edge where the last prescaler tick would have completed the window. The directed part of the bench holds a pulse one edge short of the window and then exactly as long as the window. It also rewrites a lane's window a few cycles into a qualification. A pseudo-random phase then toggles pins and rewrites small windows every 64 cycles, so such collisions occur many times. On every clock, a behavioural model that counts consecutive differing edges judges each lane's output.

// File: rtl/dgl_pkg.sv
package dgl_pkg;
  localparam int DEF_CNT_W = 4;
  localparam int DEF_SEL_W = 4;
  localparam int DEF_SYNC  = 2;

  typedef enum logic {
    LN_IDLE = 1'b0,
    LN_QUAL = 1'b1
  } lane_st_e;
endpackage

// File: rtl/dgl_sync.sv
// Multi-stage synchronizer. No reset, on purpose: the stages keep sampling
// during reset so that the clean output can track the pin before release.
module dgl_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    stg[0] <= din;
    for (int k = 1; k < STAGES; k++) begin
      stg[k] <= stg[k-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/dgl_prescale.sv
// Divide-by-2^sel tick generator, restarted by clear.
module dgl_prescale #(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int PRE_W = (1 << SEL_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] span_mask;

  // 2^sel - 1; for the largest select the shift wraps to zero and the
  // subtraction yields all ones, which is the intended mask.
  assign span_mask = (PRE_W'(1) << sel) - PRE_W'(1);
  assign tick      = ((pre_q & span_mask) == span_mask);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + PRE_W'(1);
    end
  end
endmodule

// File: rtl/dgl_qual.sv
// One lane: stability counter, held window and registered clean level.
module dgl_qual
  import dgl_pkg::*;
#(
  parameter int CNT_W = DEF_CNT_W,
  parameter int SEL_W = DEF_SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync_lvl,
  input  logic [CNT_W-1:0] cfg_cnt,
  input  logic [SEL_W-1:0] cfg_sel,
  output logic             clean,
  output logic             busy
);
  lane_st_e         st_q;
  logic             clean_q;
  logic [CNT_W-1:0] stab_q;
  logic [CNT_W-1:0] stab_nxt;
  logic [CNT_W-1:0] held_cnt;
  logic [SEL_W-1:0] held_sel;
  logic [CNT_W-1:0] eff_cnt;
  logic [SEL_W-1:0] eff_sel;
  logic             mism;
  logic             tick;
  logic             done;

  assign busy     = (st_q == LN_QUAL);
  assign eff_cnt  = busy ? held_cnt : cfg_cnt;
  assign eff_sel  = busy ? held_sel : cfg_sel;
  assign mism     = (sync_lvl != clean_q);
  assign stab_nxt = stab_q + CNT_W'(1);
  assign done     = mism && ((eff_cnt == '0) || (tick && (stab_nxt == eff_cnt)));

  dgl_prescale #(.SEL_W(SEL_W)) u_pre (
    .clk   (clk),
    .rst   (rst),
    .clear (!mism || done),
    .sel   (eff_sel),
    .tick  (tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      clean_q <= sync_lvl;
      st_q    <= LN_IDLE;
      stab_q  <= '0;
    end else if (done) begin
      clean_q <= sync_lvl;
      st_q    <= LN_IDLE;
      stab_q  <= '0;
    end else if (mism) begin
      st_q <= LN_QUAL;
      if (tick) begin
        stab_q <= stab_nxt;
      end
    end else begin
      st_q   <= LN_IDLE;
      stab_q <= '0;
    end
  end

  // Window is captured on every idle edge, including the first differing one.
  always_ff @(posedge clk) begin
    if (rst || !busy) begin
      held_cnt <= cfg_cnt;
      held_sel <= cfg_sel;
    end
  end

  assign clean = clean_q;
endmodule

// File: rtl/dgl_filter_bank.sv
module dgl_filter_bank
  import dgl_pkg::*;
#(
  parameter int NUM_PINS    = 4,
  parameter int CNT_W       = DEF_CNT_W,
  parameter int SEL_W       = DEF_SEL_W,
  parameter int SYNC_STAGES = DEF_SYNC
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_PINS-1:0]       pin_raw,
  input  logic [NUM_PINS*CNT_W-1:0] win_count,
  input  logic [NUM_PINS*SEL_W-1:0] win_select,
  output logic [NUM_PINS-1:0]       pin_clean
);
  logic [NUM_PINS-1:0] pin_sync;
  logic [NUM_PINS-1:0] lane_busy;

  dgl_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .din  (pin_raw),
    .dout (pin_sync)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_lane
    dgl_qual #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_qual (
      .clk      (clk),
      .rst      (rst),
      .sync_lvl (pin_sync[i]),
      .cfg_cnt  (win_count[i*CNT_W +: CNT_W]),
      .cfg_sel  (win_select[i*SEL_W +: SEL_W]),
      .clean    (pin_clean[i]),
      .busy     (lane_busy[i])
    );
  end
endmodule

// File: rtl/dgl_filter_bank_chk.sv
module dgl_filter_bank_chk #(
  parameter int NUM_PINS = 4,
  parameter int CNT_W    = 4,
  parameter int SEL_W    = 4
) (
  input logic                      clk,
  input logic                      rst,
  input logic [NUM_PINS-1:0]       pin_sync,
  input logic [NUM_PINS-1:0]       pin_clean,
  input logic [NUM_PINS-1:0]       lane_busy,
  input logic [NUM_PINS*CNT_W-1:0] win_count,
  input logic [NUM_PINS*SEL_W-1:0] win_select
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
    assert_to_sync_level_R8: assert property (@(posedge clk) disable iff (rst)
      !$stable(pin_clean[i]) |-> (pin_clean[i] == $past(pin_sync[i])));

    assert_quiet_when_equal_R8: assert property (@(posedge clk) disable iff (rst)
      (pin_sync[i] == pin_clean[i]) |=> $stable(pin_clean[i]));

    assert_bypass_R2: assert property (@(posedge clk) disable iff (rst)
      (!lane_busy[i] && (win_count[i*CNT_W +: CNT_W] == '0) && (pin_sync[i] != pin_clean[i]))
      |=> (pin_clean[i] == $past(pin_sync[i])));

    assert_min_window_R3: assert property (@(posedge clk) disable iff (rst)
      (!lane_busy[i] && (pin_sync[i] != pin_clean[i]) &&
       (win_count[i*CNT_W +: CNT_W] != '0) &&
       !((win_count[i*CNT_W +: CNT_W] == CNT_W'(1)) && (win_select[i*SEL_W +: SEL_W] == '0)))
      |=> $stable(pin_clean[i]));

    assert_busy_after_diff_R4: assert property (@(posedge clk) disable iff (rst)
      lane_busy[i] |-> $past(pin_sync[i] != pin_clean[i]));
  end
endmodule

bind dgl_filter_bank dgl_filter_bank_chk #(
  .NUM_PINS (NUM_PINS),
  .CNT_W    (CNT_W),
  .SEL_W    (SEL_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pin_sync   (pin_sync),
  .pin_clean  (pin_clean),
  .lane_busy  (lane_busy),
  .win_count  (win_count),
  .win_select (win_select)
);

// File: tb/sim_dgl_filter_bank.sv
module sim_dgl_filter_bank;
  localparam int NP = 4;
  localparam int CW = 4;
  localparam int SW = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NP-1:0]     pin_raw = 4'b1010;
  logic [NP*CW-1:0]  win_count = '0;
  logic [NP*SW-1:0]  win_select = '0;
  logic [NP-1:0]     pin_clean;

  always #4 clk = ~clk;

  dgl_filter_bank #(.NUM_PINS(NP), .CNT_W(CW), .SEL_W(SW)) u0 (
    .clk        (clk),
    .rst        (rst),
    .pin_raw    (pin_raw),
    .win_count  (win_count),
    .win_select (win_select),
    .pin_clean  (pin_clean)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    finished = 1'b0;
  string cur_req = "R5";

  // Behavioural reference: counts consecutive differing edges per lane.
  bit m_s1 [NP];
  bit m_s2 [NP];
  bit m_filt [NP];
  int m_run [NP];
  int m_n [NP];

  initial begin
    for (int i = 0; i < NP; i++) begin
      m_s1[i] = 1'b0; m_s2[i] = 1'b0; m_filt[i] = 1'b0; m_run[i] = 0; m_n[i] = 0;
    end
  end

  always @(posedge clk) begin
    for (int i = 0; i < NP; i++) begin
      int live;
      live = int'(win_count[i*CW +: CW]) << int'(win_select[i*SW +: SW]);
      if (rst) begin
        m_filt[i] = m_s2[i];
        m_run[i]  = 0;
      end else if (m_s2[i] != m_filt[i]) begin
        if (m_run[i] == 0) m_n[i] = live;
        m_run[i]++;
        if (m_n[i] == 0 || m_run[i] >= m_n[i]) begin
          m_filt[i] = m_s2[i];
          m_run[i]  = 0;
        end
      end else begin
        m_run[i] = 0;
      end
      m_s2[i] = m_s1[i];
      m_s1[i] = pin_raw[i];
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      for (int i = 0; i < NP; i++) begin
        n_cmp++;
        if (pin_clean[i] !== m_filt[i]) begin
          n_bad++;
          $display("FAIL %s lane %0d: clean=%0b expected=%0b (model)", cur_req, i, pin_clean[i], m_filt[i]);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input int lane, input bit exp, input string tag);
    n_cmp++;
    if (pin_clean[lane] !== exp) begin
      n_bad++;
      $display("FAIL %s lane %0d: clean=%0b expected=%0b", tag, lane, pin_clean[lane], exp);
    end
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      summary();
    end
  end

  initial begin
    logic [15:0] lfsr;
    win_count[0*CW +: CW]  = 4'd0; win_select[0*SW +: SW] = 4'd0;
    win_count[1*CW +: CW]  = 4'd3; win_select[1*SW +: SW] = 4'd2;
    win_count[2*CW +: CW]  = 4'd2; win_select[2*SW +: SW] = 4'd3;
    win_count[3*CW +: CW]  = 4'd9; win_select[3*SW +: SW] = 4'd4;
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;

    // R5: output equals pin levels right after release, and stays quiet
    for (int i = 0; i < NP; i++) chk(i, pin_raw[i], "R5 after release");
    tick(5);
    for (int i = 0; i < NP; i++) chk(i, pin_raw[i], "R5 no spurious edge");

    // R1: latency through the synchronizer with count 0
    cur_req = "R1";
    pin_raw[0] = 1'b1;
    tick(2); chk(0, 1'b0, "R1 before latency");
    tick(1); chk(0, 1'b1, "R1 at latency");

    // R2: one-clock pulse passes unfiltered
    cur_req = "R2";
    pin_raw[0] = 1'b0;
    tick(1); pin_raw[0] = 1'b1;
    tick(2); chk(0, 1'b0, "R2 narrow pulse passed");
    tick(1); chk(0, 1'b1, "R2 level restored");

    // R3: lane1 window 3<<2 = 12 edges
    cur_req = "R3";
    pin_raw[1] = 1'b0;
    tick(13); chk(1, 1'b1, "R3 one edge early");
    tick(1);  chk(1, 1'b0, "R3 exact window");

    // R4: pulse one edge short is rejected, then a fresh full window is needed
    cur_req = "R4";
    pin_raw[1] = 1'b1;
    tick(11); pin_raw[1] = 1'b0;
    tick(20); chk(1, 1'b0, "R4 short pulse rejected");
    pin_raw[1] = 1'b1;
    tick(13); chk(1, 1'b0, "R4 progress discarded");
    tick(1);  chk(1, 1'b1, "R4 full window again");

    // R6: rewrite lane2 window mid-qualification
    cur_req = "R6";
    pin_raw[2] = 1'b1;
    tick(4);
    win_count[2*CW +: CW] = 4'd1; win_select[2*SW +: SW] = 4'd0;
    tick(13); chk(2, 1'b0, "R6 held window, before end");
    tick(1);  chk(2, 1'b1, "R6 held window, at end");
    pin_raw[2] = 1'b0;
    tick(2); chk(2, 1'b1, "R6 new window, before");
    tick(1); chk(2, 1'b0, "R6 new window applied");

    // R9: select 4, count 9 -> 144 cycles
    cur_req = "R9";
    pin_raw[3] = 1'b0;
    tick(145); chk(3, 1'b1, "R9 one edge early");
    tick(1);   chk(3, 1'b0, "R9 144-cycle window");

    // R7: all lanes at once with random pins and window rewrites
    cur_req = "R7";
    lfsr = 16'hACE1;
    for (int c = 0; c < 4000; c++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      for (int i = 0; i < NP; i++) begin
        if (lfsr[i*3 +: 3] == 3'd0) pin_raw[i] = ~pin_raw[i];
      end
      if (c % 64 == 0) begin
        for (int i = 0; i < NP; i++) begin
          win_count[i*CW +: CW]  = CW'(lfsr[i*2 +: 2]);
          win_select[i*SW +: SW] = SW'(lfsr[(i*2+8) +: 2]);
        end
      end
      tick(1);
    end

    // R5: mid-run reset tracks pins, no edge after release
    cur_req = "R5";
    rst = 1'b1;
    pin_raw = 4'b0110;
    tick(4);
    rst = 1'b0;
    for (int i = 0; i < NP; i++) chk(i, pin_raw[i], "R5 second reset");
    tick(3);
    for (int i = 0; i < NP; i++) chk(i, pin_raw[i], "R5 quiet after second reset");

    summary();
  end
endmodule